// File: doc/BRIEF.md
# Integer ALU with Trap Checks

This block is the integer execution unit of a small load/store processor. It is purely combinational: an opcode and two 32-bit operands go in, and a 32-bit result and a trap flag come out in the same cycle. The second operand has already been chosen upstream. It is either a register value or a sign-extended 16-bit immediate. The unit does not need to know which.

The unit covers the following operations:
- add and subtract;
- a three-way compare;
- signed multiply, divide and remainder;
- four bitwise operations;
- two shifts whose count is signed;
- a bounds check.

The trap flag reports four conditions:
- a shift count that is out of range;
- a bounds check that fails;
- a division or remainder by zero;
- any opcode the unit does not implement.

The surrounding pipeline decides what a trap means. There is no data stream here, so the ports are plain signals with no handshake.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts, both wrapping modulo 2^32. Every implemented opcode in the range 0..15 behaves exactly like that opcode plus 16 (the immediate form). Implemented operations leave the trap flag low unless a requirement below raises it.
- R2: Opcode 5 (compare) returns 32'hFFFFFFFF when the signed difference of operand A minus operand B is negative, 1 when it is positive, and 0 when the operands are equal.
- R3: Opcode 2 returns the low 32 bits of the signed product A times B.
- R4: Opcode 3 returns the signed quotient A / B, truncated toward zero.
- R5: Opcode 4 returns the signed remainder of A / B. The remainder is zero or has the sign of A.
- R6: Opcodes 3 and 4 with B equal to zero raise the trap flag and return 0.
- R7: The bitwise operations are opcode 8 (A OR B), opcode 9 (A AND B), opcode 10 (A AND NOT B, bit clear) and opcode 11 (A XOR B).
- R8: Opcodes 12 (logical) and 13 (arithmetic) take B as a signed count.
  - A count of 0 or more shifts A left by that count.
  - A negative count shifts A right by the count's magnitude.
  - Opcode 12 fills the vacated top bits with zeros. Opcode 13 fills them with copies of A's bit 31.
- R9: A shift count below -31 or above 31 raises the trap flag and returns 0.
- R10: Opcode 14 (bounds check) returns A unchanged. It raises the trap flag when A is negative, or when A is greater than or equal to B as signed values.
- R11: Opcodes 6, 7 and 15, their immediate forms 22, 23 and 31, and every opcode from 32 to 63 raise the trap flag and return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 6 | Operation code; bit 4 selects the immediate form and does not change behaviour |
| opa_i | input | 32 | First operand (register value) |
| opb_i | input | 32 | Second operand (register value or sign-extended immediate) |
| result_o | output | 32 | Operation result |
| trap_o | output | 1 | Trap flag: bad shift count, failed bounds check, zero divisor or unknown opcode |

## Verification
The unit holds no state, so a fault in one of its internal paths shows up at the ports in the same cycle its inputs select that path. Examples are a wrong sign fix-up in the divider, a shift that uses the wrong fill, or a compare that loses the borrow. The risk is that such a fault only appears for particular operand signs or edges. For that reason each operation is driven with mixed-sign operands and at the count and bound limits: ±31, ±32, equality at the bound, and a zero divisor. Each result and the trap flag are sampled half a clock after the inputs change.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  localparam int OPC_W = 6;

  // Low four opcode bits select the function; bit 4 marks the immediate form.
  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_MUL = 4'd2,
    FN_DIV = 4'd3,
    FN_MOD = 4'd4,
    FN_CMP = 4'd5,
    FN_OR  = 4'd8,
    FN_AND = 4'd9,
    FN_BIC = 4'd10,
    FN_XOR = 4'd11,
    FN_LSH = 4'd12,
    FN_ASH = 4'd13,
    FN_CHK = 4'd14
  } fn_e;

  function automatic logic fn_known(input logic [OPC_W-1:0] op);
    logic [3:0] f;
    f = op[3:0];
    return !op[5] && (f != 4'd6) && (f != 4'd7) && (f != 4'd15);
  endfunction

endpackage

// File: rtl/iexu_compare.sv
module iexu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs_i,
  input  logic [W-1:0] rhs_i,
  output logic [W-1:0] tri_o,
  output logic         less_o
);
  logic [W:0] diff;

  always_comb begin
    diff   = {lhs_i[W-1], lhs_i} - {rhs_i[W-1], rhs_i};
    less_o = diff[W];
    if (diff[W])      tri_o = '1;
    else if (diff == '0) tri_o = '0;
    else              tri_o = W'(1);
  end

  always_comb begin
    AST_CMP_TRISTATE: assert (tri_o == '0 || tri_o == '1 || tri_o == W'(1))
      else $error("compare left the three-value set"); // R2
    if (lhs_i == rhs_i)
      AST_CMP_EQUAL_ZERO: assert (tri_o == '0 && !less_o)
        else $error("equal operands not reported as zero"); // R2
  end

endmodule

// File: rtl/iexu_divider.sv
module iexu_divider #(
  parameter int W = 32
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         zero_den_o
);
  logic [W-1:0] mag_n, mag_d, uq, ur;
  logic         flip_q;

  always_comb begin
    mag_n      = num_i[W-1] ? (~num_i + W'(1)) : num_i;
    mag_d      = den_i[W-1] ? (~den_i + W'(1)) : den_i;
    zero_den_o = (den_i == '0);
    flip_q     = num_i[W-1] ^ den_i[W-1];
    if (zero_den_o) begin
      uq = '0;
      ur = '0;
    end else begin
      uq = mag_n / mag_d;
      ur = mag_n % mag_d;
    end
    quo_o = flip_q ? (~uq + W'(1)) : uq;
    rem_o = num_i[W-1] ? (~ur + W'(1)) : ur;
  end

  always_comb begin
    if (rem_o != '0)
      AST_REM_FOLLOWS_DIVIDEND: assert (rem_o[W-1] == num_i[W-1])
        else $error("remainder sign differs from dividend"); // R5
    if (den_i == '0)
      AST_ZERO_DIVISOR_CLEAR: assert (quo_o == '0 && rem_o == '0)
        else $error("zero divisor produced nonzero output"); // R6
  end

endmodule

// File: rtl/iexu_shifter.sv
module iexu_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] cnt_i,
  input  logic         arith_i,
  output logic [W-1:0] res_o,
  output logic         range_err_o
);
  localparam int SH_W  = $clog2(W);
  localparam int MAX_C = W - 1;

  logic            go_right;
  logic [W-1:0]    mag;
  logic [SH_W-1:0] amt;

  always_comb begin
    range_err_o = ($signed(cnt_i) > MAX_C) || ($signed(cnt_i) < -MAX_C);
    go_right    = cnt_i[W-1];
    mag         = go_right ? (~cnt_i + W'(1)) : cnt_i;
    amt         = mag[SH_W-1:0];
    if (range_err_o)   res_o = '0;
    else if (!go_right) res_o = val_i << amt;
    else if (arith_i)  res_o = W'($signed(val_i) >>> amt);
    else               res_o = val_i >> amt;
  end

  always_comb begin
    if (!range_err_o && !go_right)
      AST_LEFT_LOW_CLEAR: assert ((res_o & ((W'(1) << amt) - W'(1))) == '0)
        else $error("left shift left low bits set"); // R8
    if (!range_err_o && go_right && arith_i)
      AST_ARITH_KEEPS_SIGN: assert (res_o[W-1] == val_i[W-1])
        else $error("arithmetic right shift lost sign"); // R8
    if (!range_err_o && go_right && !arith_i && amt != '0)
      AST_LOGIC_TOP_ZERO: assert (res_o[W-1] == 1'b0)
        else $error("logical right shift filled with ones"); // R8
    if (range_err_o)
      AST_BAD_COUNT_QUIET: assert (res_o == '0)
        else $error("out-of-range count gave data"); // R9
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPC_W-1:0] op_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  output logic [W-1:0]     result_o,
  output logic             trap_o
);
  logic         known;
  fn_e          fn;
  logic [W-1:0] cmp_tri, quo, rem, sh_res;
  logic         cmp_less, zero_den, sh_err;

  iexu_compare #(.W(W)) u_cmp (
    .lhs_i(opa_i), .rhs_i(opb_i), .tri_o(cmp_tri), .less_o(cmp_less)
  );

  iexu_divider #(.W(W)) u_div (
    .num_i(opa_i), .den_i(opb_i), .quo_o(quo), .rem_o(rem), .zero_den_o(zero_den)
  );

  iexu_shifter #(.W(W)) u_shf (
    .val_i(opa_i), .cnt_i(opb_i), .arith_i(op_i[0]),
    .res_o(sh_res), .range_err_o(sh_err)
  );

  always_comb begin
    known    = fn_known(op_i);
    fn       = fn_e'(op_i[3:0]);
    result_o = '0;
    trap_o   = 1'b0;
    if (!known) begin
      trap_o = 1'b1;
    end else begin
      unique case (fn)
        FN_ADD: result_o = opa_i + opb_i;
        FN_SUB: result_o = opa_i - opb_i;
        FN_MUL: result_o = W'($signed(opa_i) * $signed(opb_i));
        FN_DIV: begin result_o = quo; trap_o = zero_den; end
        FN_MOD: begin result_o = rem; trap_o = zero_den; end
        FN_CMP: result_o = cmp_tri;
        FN_OR:  result_o = opa_i | opb_i;
        FN_AND: result_o = opa_i & opb_i;
        FN_BIC: result_o = opa_i & ~opb_i;
        FN_XOR: result_o = opa_i ^ opb_i;
        FN_LSH, FN_ASH: begin result_o = sh_res; trap_o = sh_err; end
        FN_CHK: begin
          result_o = opa_i;
          trap_o   = opa_i[W-1] | ~cmp_less;
        end
        default: trap_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (!fn_known(op_i))
      AST_UNKNOWN_OP_TRAPS: assert (trap_o && result_o == '0)
        else $error("unknown opcode not trapped"); // R11
    if (fn_known(op_i) && op_i[3:0] == 4'd14)
      AST_CHECK_PASSES_A: assert (result_o == opa_i)
        else $error("bounds check altered operand"); // R10
    if (fn_known(op_i) && op_i[3:0] == 4'd14 && opa_i[W-1])
      AST_CHECK_NEG_TRAPS: assert (trap_o)
        else $error("negative index passed bounds check"); // R10
  end

endmodule

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;
  logic        clk = 1'b0;
  logic [5:0]  op;
  logic [31:0] a, b;
  logic [31:0] res;
  logic        trap;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  int_exec_unit uut (.op_i(op), .opa_i(a), .opb_i(b), .result_o(res), .trap_o(trap));

  task automatic apply(input logic [5:0] o, input logic [31:0] x, input logic [31:0] y);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_t);
    n_run++;
    if (res !== exp_r || trap !== exp_t) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: result=%h trap=%b, expected result=%h trap=%b",
               tag, op, a, b, res, trap, exp_r, exp_t);
    end
  endtask

  task automatic t_idle;
    check("R1 idle", 32'd0, 1'b0);
  endtask

  task automatic t_addsub;
    apply(6'd0, 32'd7, -32'sd3);           check("R1 add", 32'd4, 1'b0);
    apply(6'd16, 32'd7, -32'sd3);          check("R1 addi", 32'd4, 1'b0);
    apply(6'd1, 32'd5, 32'd9);             check("R1 sub", -32'sd4, 1'b0);
    apply(6'd17, 32'd5, 32'd9);            check("R1 subi", -32'sd4, 1'b0);
    apply(6'd0, 32'h7FFFFFFF, 32'd1);      check("R1 wrap", 32'h80000000, 1'b0);
  endtask

  task automatic t_compare;
    apply(6'd5, 32'd3, 32'd9);             check("R2 less", 32'hFFFFFFFF, 1'b0);
    apply(6'd5, 32'd9, 32'd3);             check("R2 greater", 32'd1, 1'b0);
    apply(6'd5, 32'd4, 32'd4);             check("R2 equal", 32'd0, 1'b0);
    apply(6'd21, -32'sd5, -32'sd5);        check("R2 cmpi equal", 32'd0, 1'b0);
    apply(6'd21, -32'sd5, 32'd2);          check("R2 cmpi mixed sign", 32'hFFFFFFFF, 1'b0);
  endtask

  task automatic t_mul;
    apply(6'd2, -32'sd3, 32'd7);           check("R3 mul neg", -32'sd21, 1'b0);
    apply(6'd18, 32'h00010000, 32'h00010000); check("R3 muli low bits", 32'd0, 1'b0);
  endtask

  task automatic t_divmod;
    apply(6'd3, -32'sd7, 32'd2);           check("R4 div neg dividend", -32'sd3, 1'b0);
    apply(6'd3, 32'd7, -32'sd2);           check("R4 div neg divisor", -32'sd3, 1'b0);
    apply(6'd19, 32'd100, 32'd7);          check("R4 divi", 32'd14, 1'b0);
    apply(6'd4, -32'sd7, 32'd2);           check("R5 mod neg dividend", -32'sd1, 1'b0);
    apply(6'd4, 32'd7, -32'sd2);           check("R5 mod neg divisor", 32'd1, 1'b0);
    apply(6'd3, 32'd55, 32'd0);            check("R6 div zero", 32'd0, 1'b1);
    apply(6'd20, -32'sd9, 32'd0);          check("R6 modi zero", 32'd0, 1'b1);
  endtask

  task automatic t_logic;
    apply(6'd8, 32'hF0F01234, 32'h0FF000FF);  check("R7 or", 32'hFFF012FF, 1'b0);
    apply(6'd9, 32'hF0F01234, 32'h0FF000FF);  check("R7 and", 32'h00F00034, 1'b0);
    apply(6'd10, 32'hF0F01234, 32'h0FF000FF); check("R7 bic", 32'hF0001200, 1'b0);
    apply(6'd11, 32'hF0F01234, 32'h0FF000FF); check("R7 xor", 32'hFF0012CB, 1'b0);
    apply(6'd26, 32'hF0F01234, 32'h0FF000FF); check("R7 bici", 32'hF0001200, 1'b0);
  endtask

  task automatic t_shift;
    apply(6'd12, 32'd1, 32'd4);            check("R8 lsh left", 32'd16, 1'b0);
    apply(6'd12, 32'd1, 32'd31);           check("R8 lsh left 31", 32'h80000000, 1'b0);
    apply(6'd12, 32'h80000000, -32'sd31);  check("R8 lsh right 31", 32'd1, 1'b0);
    apply(6'd13, 32'h80000000, -32'sd31);  check("R8 ash right 31", 32'hFFFFFFFF, 1'b0);
    apply(6'd12, 32'hFFFFFF00, -32'sd4);   check("R8 lsh zero fill", 32'h0FFFFFF0, 1'b0);
    apply(6'd13, 32'hFFFFFF00, -32'sd4);   check("R8 ash sign fill", 32'hFFFFFFF0, 1'b0);
    apply(6'd29, 32'h7FFFFF00, -32'sd4);   check("R8 ashi positive", 32'h07FFFFF0, 1'b0);
    apply(6'd28, 32'd3, 32'd2);            check("R8 lshi", 32'd12, 1'b0);
    apply(6'd12, 32'd1, 32'd32);           check("R9 lsh count 32", 32'd0, 1'b1);
    apply(6'd13, 32'hFFFF0000, -32'sd32);  check("R9 ash count -32", 32'd0, 1'b1);
  endtask

  task automatic t_bounds;
    apply(6'd14, 32'd5, 32'd10);           check("R10 inside", 32'd5, 1'b0);
    apply(6'd14, 32'd0, 32'd1);            check("R10 zero index", 32'd0, 1'b0);
    apply(6'd14, 32'd10, 32'd10);          check("R10 at bound", 32'd10, 1'b1);
    apply(6'd14, 32'hFFFFFFFF, 32'd10);    check("R10 negative", 32'hFFFFFFFF, 1'b1);
    apply(6'd30, 32'd9, 32'd10);           check("R10 chki inside", 32'd9, 1'b0);
  endtask

  task automatic t_badop;
    logic [5:0] bad [7] = '{6'd6, 6'd7, 6'd15, 6'd22, 6'd31, 6'd32, 6'd63};
    for (int i = 0; i < 7; i++) begin
      apply(bad[i], 32'd123, 32'd4);
      check("R11 unknown opcode", 32'd0, 1'b1);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0;
    @(negedge clk);
    t_idle();
    t_addsub();
    t_compare();
    t_mul();
    t_divmod();
    t_logic();
    t_shift();
    t_bounds();
    t_badop();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule